// File: doc/BRIEF.md
# Serial Comma Word Aligner

This block takes a serial bit stream, one bit on each clock cycle in which a bit-enable is asserted, and cuts it into 10-bit words. It watches every bit position for the seven-bit comma that opens the K28.5 control character. When a comma appears on a position other than the current word boundary, it moves the boundary to that comma. It does not emit a short or glitched word while it does this. Instead it suppresses the strobe for the damaged word, so the gap between two strobes grows.

Each delivered word comes with a one-cycle valid strobe and a sync flag. The word and the flag are held until the next word arrives. The sync flag marks a word that begins with the comma. An alignment-enable input allows or blocks boundary moves. While it is low, the boundary stays where it is and the words keep their cadence.

A controller state machine tracks the boundary. It has three states:
- `ST_HUNT`: no comma has been seen since reset. The boundary still sits where the reset left it.
- `ST_SLIP`: the boundary has just been moved, and the first word framed on the new boundary has not yet been delivered.
- `ST_LOCK`: the boundary is confirmed, either by a comma found on it or by the first word framed after a move.

The controller has five transitions:
- HUNT to LOCK on an enabled comma that lies on the boundary.
- HUNT to SLIP on an enabled comma that lies off the boundary.
- SLIP to LOCK when the next word completes.
- LOCK to SLIP on an enabled comma that lies off the boundary.
- SLIP to SLIP when another enabled comma arrives off the boundary before the next word completes.

Top module: `comma_word_aligner`

## Requirements
- R1: Bit 0 of `word_out` is the earliest received bit of the word and bit 9 is the latest.
- R2: While `rst_n` is low, and until the first strobe after it, `word_out`, `word_vld` and `sync_flag` are 0. After reset, the first word completes on the 10th accepted bit.
- R3: Without a boundary move, `word_vld` pulses once every 10 accepted bits. Each pulse lasts exactly one clock cycle: the cycle after the clock edge at which the 10th bit was accepted.
- R4: A comma is a window of seven bits whose earliest two bits are 0 and whose next five bits are 1. Inside a word this is `word_out[6:0] == 7'b1111100`.
- R5: A comma that lies on the current boundary, meaning its word completes on a strobe bit, leaves the boundary and the cadence unchanged.
- R6: With `align_en` high, a comma whose 10-bit word would complete on a bit that is not a strobe bit moves the boundary. No strobe is given on that bit. The next strobe follows exactly 10 accepted bits later, and every later word is framed on the comma.
- R7: Two successive strobes are never fewer than 10 and never more than 19 accepted bits apart.
- R8: `sync_flag` is 1 exactly while the held word satisfies R4. It changes only together with a strobe.
- R9: With `align_en` low, a comma off the boundary is ignored, and strobes keep their 10-bit cadence.
- R10: A cycle with `bit_en` low shifts nothing, advances nothing and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| align_en | input | 1 | Allows boundary moves on comma detection |
| word_out | output | 10 | Latest delivered word, bit 0 received first |
| word_vld | output | 1 | One-cycle strobe for a new word |
| sync_flag | output | 1 | Held word begins with the comma |

## Verification
The strobe-gap and single-pulse properties rely on one assumption about the input: every comma after the first arrives a whole number of words after the previous one. A legal 8b/10b stream behaves this way, and it is what keeps a repeated boundary move from stretching a gap past 19 bits. The stimulus meets this assumption. Each run places filler zeros, then a K28.5, a data word, a second K28.5 and another data word. The two commas are therefore exactly 20 bits apart. The only thing that varies from run to run is where the first comma falls relative to the reset boundary.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    localparam int unsigned WORD_W_DEF  = 10;
    localparam int unsigned COMMA_W_DEF = 7;
    // earliest received bit in position 0: 0,0,1,1,1,1,1
    localparam logic [6:0]  COMMA_PAT_DEF = 7'b1111100;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SLIP = 2'd1,
        ST_LOCK = 2'd2
    } align_state_t;

endpackage

// File: rtl/cwa_shift.sv
module cwa_shift #(
    parameter int unsigned WORD_W = cwa_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] win_next
);

    // newest WORD_W-1 bits; the incoming bit completes the window
    logic [WORD_W-2:0] hist_q;

    always_comb begin
        win_next = {bit_in, hist_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_en) begin
            hist_q <= win_next[WORD_W-1:1];
        end
    end

    assert_shift_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> (hist_q[WORD_W-2] == $past(bit_in)));

    assert_shift_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(hist_q));

endmodule

// File: rtl/cwa_comma_det.sv
module cwa_comma_det #(
    parameter int unsigned             COMMA_W   = cwa_pkg::COMMA_W_DEF,
    parameter logic [COMMA_W-1:0]      COMMA_PAT = cwa_pkg::COMMA_PAT_DEF
) (
    input  logic [COMMA_W-1:0] win_lo,
    output logic               hit
);

    logic [COMMA_W-1:0] bit_ok;

    for (genvar g = 0; g < COMMA_W; g++) begin : g_cmp
        assign bit_ok[g] = (win_lo[g] == COMMA_PAT[g]);
    end

    assign hit = &bit_ok;

endmodule

// File: rtl/cwa_ctrl.sv
module cwa_ctrl
    import cwa_pkg::*;
#(
    parameter int unsigned WORD_W = cwa_pkg::WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         align_en,
    input  logic         comma_hit,
    output logic         emit,
    output align_state_t state
);

    localparam int unsigned     CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    align_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_edge;
    logic             realign;
    logic             comma_ok;

    always_comb begin
        at_edge  = (cnt_q == LAST);
        comma_ok = bit_en && align_en && comma_hit;
        realign  = comma_ok && !at_edge;
    end

    // output process
    always_comb begin
        emit  = bit_en && at_edge;
        state = state_q;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (comma_ok) state_d = at_edge ? ST_LOCK : ST_SLIP;
            end
            ST_SLIP: begin
                if (realign)   state_d = ST_SLIP;
                else if (emit) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (realign) state_d = ST_SLIP;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_en) begin
            if (realign || at_edge) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // gap tracker for the strobe spacing check
    logic [4:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (bit_en) begin
            if (emit) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != 5'd31) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_gap_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && seen_q) |-> (gap_q >= 5'd9 && gap_q <= 5'd18));

    assert_aligned_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && bit_en && comma_hit && cnt_q == LAST) |=> (state_q == ST_LOCK));

    assert_realign_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && align_en && comma_hit && cnt_q != LAST) |=> (state_q == ST_SLIP && cnt_q == '0));

    assert_freeze_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_en && state_q == ST_LOCK) |=> (state_q == ST_LOCK));

    assert_freeze_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_en && state_q == ST_HUNT) |=> (state_q == ST_HUNT));

    assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cnt_q));

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
    import cwa_pkg::*;
#(
    parameter int unsigned        WORD_W    = cwa_pkg::WORD_W_DEF,
    parameter int unsigned        COMMA_W   = cwa_pkg::COMMA_W_DEF,
    parameter logic [COMMA_W-1:0] COMMA_PAT = cwa_pkg::COMMA_PAT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              align_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              sync_flag
);

    logic [WORD_W-1:0] win_next;
    logic              comma_hit;
    logic              emit;
    align_state_t      state;
    logic [WORD_W-1:0] word_q;
    logic              vld_q;
    logic              sync_q;

    cwa_shift #(.WORD_W(WORD_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_next (win_next)
    );

    cwa_comma_det #(.COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) det_i (
        .win_lo (win_next[COMMA_W-1:0]),
        .hit    (comma_hit)
    );

    cwa_ctrl #(.WORD_W(WORD_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .align_en  (align_en),
        .comma_hit (comma_hit),
        .emit      (emit),
        .state     (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            vld_q <= emit;
            if (emit) begin
                word_q <= win_next;
                sync_q <= comma_hit;
            end
        end
    end

    assign word_out  = word_q;
    assign word_vld  = vld_q;
    assign sync_flag = sync_q;

    assert_vld_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    assert_vld_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(bit_en));

    assert_sync_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_flag |-> (word_out[COMMA_W-1:0] == COMMA_PAT));

    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> ($stable(word_out) && $stable(sync_flag)));

    assert_state_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);

endmodule

// File: tb/comma_word_aligner_tb_top.sv
module comma_word_aligner_tb_top;

    localparam int        NUM_CASES = 9;
    localparam logic [9:0] KWORD    = 10'b0101111100;
    localparam logic [9:0] DWORD    = 10'b0101010101;
    // bit7: idle cycle after every bit, bit6: align_en, bits5:0: filler length
    localparam logic [7:0] CASES [NUM_CASES] = '{
        8'h40, 8'h43, 8'h49, 8'h41, 8'h05, 8'h4A, 8'hC4, 8'h00, 8'h4E
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] word_out;
    logic       word_vld;
    logic       sync_flag;

    int checks = 0;
    int errors = 0;
    logic stream [1:128];

    always #4 clk = ~clk;

    comma_word_aligner dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .align_en  (align_en),
        .word_out  (word_out),
        .word_vld  (word_vld),
        .sync_flag (sync_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(word_out == 10'd0 && !word_vld && !sync_flag, "R2 reset outputs",
            {word_out, word_vld, sync_flag}, 0);
        rst_n = 1'b1;
    endtask

    // called at a negedge; returns at the following negedge with outputs sampled
    task automatic send_bit(input logic b);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    function automatic bit exp_strobe(input int i, input int n, input bit en);
        if (n % 10 == 0 || !en) return (i % 10 == 0);
        return ((i <= n + 9) && (i % 10 == 0)) || ((i >= n + 20) && ((i - n) % 10 == 0));
    endfunction

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NUM_CASES; c++) begin
            int  n;
            int  len;
            bit  en;
            bit  idle;
            n    = int'(CASES[c][5:0]);
            en   = CASES[c][6];
            idle = CASES[c][7];
            len  = n + 40;
            for (int i = 1; i <= n; i++) stream[i] = 1'b0;
            for (int k = 0; k < 10; k++) begin
                stream[n + 1 + k]  = KWORD[k];
                stream[n + 11 + k] = DWORD[k];
                stream[n + 21 + k] = KWORD[k];
                stream[n + 31 + k] = DWORD[k];
            end
            do_reset();
            align_en = en;
            for (int i = 1; i <= len; i++) begin
                bit         ev;
                logic [9:0] ew;
                send_bit(stream[i]);
                ev = exp_strobe(i, n, en);
                // R3 R6 R7 R9: strobe position
                chk(word_vld == ev, en ? "R6 strobe position" : "R9 strobe position",
                    int'(word_vld), int'(ev));
                if (ev && word_vld) begin
                    for (int k = 0; k < 10; k++) ew[k] = stream[i - 9 + k];
                    chk(word_out == ew, "R1 word content", int'(word_out), int'(ew));
                    chk(sync_flag == (ew[6:0] == 7'b1111100), "R4 R8 sync flag",
                        int'(sync_flag), int'(ew[6:0] == 7'b1111100));
                end
                if (idle) begin
                    @(negedge clk);
                    chk(!word_vld, "R10 idle no strobe", int'(word_vld), 0);
                end
            end
        end

        // R2: reset mid-stream clears a held word
        do_reset();
        align_en = 1'b1;
        for (int k = 0; k < 10; k++) send_bit(KWORD[k]);
        chk(word_vld && sync_flag && word_out == KWORD, "R5 first word on boundary",
            int'(word_out), int'(KWORD));
        @(negedge clk);
        chk(!word_vld && word_out == KWORD, "R8 word held", int'(word_out), int'(KWORD));
        rst_n = 1'b0;
        @(negedge clk);
        chk(word_out == 10'd0 && !sync_flag && !word_vld, "R2 reset clears",
            int'(word_out), 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule